// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences a 10-bit successive-approximation analog-to-digital conversion. Software controls it with a small control write: an enable, a start/busy bit, and a justification select. A one-cycle conversion tick marks each conversion period. The block drives a trial code to an external DAC and reads back one comparator decision per period. It controls the sample switch of the holding capacitor, packs the finished result into a pair of bytes, and raises a sticky completion flag.

The controller has three states. In `ST_IDLE` the capacitor tracks the input. A valid start write moves the controller to `ST_ALIGN`, which waits for the next tick, so this first period lasts anywhere from one clock to one full period. That tick moves the controller to `ST_CONV`, which spends ten ticks resolving the bits from the most significant down. The final tick loads the result and returns to `ST_IDLE`. Named transitions:
- start (`ST_IDLE`→`ST_ALIGN`)
- align (`ST_ALIGN`→`ST_CONV`)
- finish (`ST_CONV`→`ST_IDLE`)
- abort (`ST_ALIGN` or `ST_CONV`→`ST_IDLE`)

Top module: `sar_seq`

## Requirements
- R1: After reset the block is disabled, `busy` is 0, `sample_on` is 1, `dac_code` is 0, `irq_flag` is 0, and both result bytes are 0.
- R2: A control write with `ctl_go`=1 starts a conversion only if the block was already enabled before that write and the write keeps `ctl_en`=1. A start while disabled, or in the same write that enables the block, leaves `busy` at 0.
- R3: On the cycle after an accepted start, `busy` is 1 and `sample_on` is 0. `dac_code` stays 0 until the first `conv_tick`, however many cycles that tick takes to arrive.
- R4: The first `conv_tick` after a start ends the alignment period, and on the next cycle `dac_code` is 0x200 (only bit 9 set).
- R5: On each later tick, the trial bit is cleared if `cmp_below`=1 and kept otherwise, and the next lower bit is then set. After the tick that resolves bit k (k>0), `dac_code` holds the resolved bits 9..k with bit k-1 set and all lower bits 0.
- R6: The tenth tick after alignment (the one that resolves bit 0) completes the conversion. On the next cycle `busy` is 0, `sample_on` is 1, `irq_flag` is 1, `dac_code` is 0, and the result bytes hold the new result.
- R7: With the format bit 0 at load time the result is left justified: `res_hi` = result[9:2] and `res_lo` = {result[1:0], 000000}.
- R8: With the format bit 1 at load time the result is right justified: `res_hi` = {000000, result[9:8]} and `res_lo` = result[7:0].
- R9: A control write with `ctl_go`=0 during `ST_ALIGN` or `ST_CONV` aborts the conversion. On the next cycle `busy` is 0 and `sample_on` is 1. The result bytes keep their previous value, `irq_flag` does not set, and later ticks have no effect until a new start.
- R10: `irq_flag` stays 1 until a cycle with `flag_clr`=1. A completion in the same cycle as a clear wins.
- R11: `res_hi_we` and `res_lo_we` write `res_wdata` into the high and low byte. This lets the pair serve as two general-purpose registers while the block is disabled. A completion load in the same cycle wins.
- R12: A control write with `ctl_en`=0 during a conversion disables the block and aborts the conversion, with the same effects as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable value written |
| ctl_go | input | 1 | Start/busy value written |
| ctl_fmt | input | 1 | Justification value written (0 left, 1 right) |
| flag_clr | input | 1 | Clears the completion flag |
| res_hi_we | input | 1 | Write strobe for the high result byte |
| res_lo_we | input | 1 | Write strobe for the low result byte |
| res_wdata | input | 8 | Data for result byte writes |
| conv_tick | input | 1 | One pulse per conversion period |
| cmp_below | input | 1 | Comparator: input is below the DAC level |
| busy | output | 1 | Start/busy bit as read back |
| sample_on | output | 1 | Sample switch closed (capacitor tracks input) |
| dac_code | output | 10 | Trial code for the DAC |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |
| irq_flag | output | 1 | Sticky completion flag |

## Verification
On every cycle the assertions check the following:
- a rising `busy` always follows an already-enabled state;
- an abort always empties the pipeline without touching the result;
- the bit index walks down by one per tick;
- a load always raises the flag and zero-fills the pad bits for the chosen justification;
- the flag holds until cleared.

Only the bench scenarios show that the whole search finds the right answer. The bench applies every one of the 1024 input levels and compares each intermediate trial code and each packed result with values derived arithmetically. The scenarios also cover the refused start cases, abort and disable mid-search, and the variable length of the alignment period.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_CONV  = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_ctl.sv
module sar_ctl
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic ctl_en,
    input  logic ctl_go,
    input  logic conv_tick,
    input  logic last_bit,
    output logic en_q,
    output logic busy,
    output logic sample_on,
    output logic align_fire,
    output logic step_fire,
    output logic load_fire,
    output logic abort_fire
);
    sar_state_e state_q, state_d;
    logic start_req;

    // a start counts only if the block was enabled before this write
    assign start_req  = ctl_we && ctl_go && ctl_en && en_q;
    assign abort_fire = ctl_we && (!ctl_go || !ctl_en) && (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) state_d = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (abort_fire)     state_d = ST_IDLE;
                else if (conv_tick) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (abort_fire)                 state_d = ST_IDLE;
                else if (conv_tick && last_bit) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctl_we) en_q <= ctl_en;
        end
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        sample_on  = (state_q == ST_IDLE);
        align_fire = (state_q == ST_ALIGN) && conv_tick && !abort_fire;
        step_fire  = (state_q == ST_CONV) && conv_tick && !abort_fire;
        load_fire  = step_fire && last_bit;
    end

    assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en_q));
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_fire |=> (!busy && sample_on));
endmodule

// File: rtl/sar_step.sv
module sar_step #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_fire,
    input  logic             step_fire,
    input  logic             clr,
    input  logic             cmp_below,
    output logic [RES_W-1:0] code,
    output logic [RES_W-1:0] resolved,
    output logic             last_bit
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] next_code;

    always_comb begin
        resolved = code;
        if (cmp_below) resolved[idx] = 1'b0;
        next_code = resolved;
        if (idx != '0) next_code[idx - IDX_W'(1)] = 1'b1;
    end

    assign last_bit = (idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            idx  <= '0;
        end else if (clr) begin
            code <= '0;
            idx  <= '0;
        end else if (align_fire) begin
            code <= MSB_ONE;
            idx  <= IDX_W'(RES_W - 1);
        end else if (step_fire) begin
            code <= next_code;
            idx  <= idx - IDX_W'(1);
        end
    end

    assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (align_fire && !clr) |=> (code == MSB_ONE));
    assert_idx_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fire && !clr && idx != '0) |=> (idx == $past(idx) - IDX_W'(1)));
endmodule

// File: rtl/sar_pack.sv
module sar_pack #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]    value,
    input  logic                right_just,
    output logic [2*BYTE_W-1:0] pair
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                if (right_just) pair = {{PAD_W{1'b0}}, value};
                else            pair = {value, {PAD_W{1'b0}}};
            end
        end else begin : g_fit
            assign pair = value;
        end
    endgenerate
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_en,
    input  logic              ctl_go,
    input  logic              ctl_fmt,
    input  logic              flag_clr,
    input  logic              res_hi_we,
    input  logic              res_lo_we,
    input  logic [BYTE_W-1:0] res_wdata,
    input  logic              conv_tick,
    input  logic              cmp_below,
    output logic              busy,
    output logic              sample_on,
    output logic [RES_W-1:0]  dac_code,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic              irq_flag
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic en_q, fmt_q;
    logic align_fire, step_fire, load_fire, abort_fire, last_bit;
    logic [RES_W-1:0]  resolved;
    logic [PAIR_W-1:0] packed_val, res_q;

    sar_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_go(ctl_go),
        .conv_tick(conv_tick), .last_bit(last_bit), .en_q(en_q), .busy(busy),
        .sample_on(sample_on), .align_fire(align_fire), .step_fire(step_fire),
        .load_fire(load_fire), .abort_fire(abort_fire)
    );

    sar_step #(.RES_W(RES_W)) u_step (
        .clk(clk), .rst_n(rst_n), .align_fire(align_fire), .step_fire(step_fire),
        .clr(load_fire || abort_fire), .cmp_below(cmp_below), .code(dac_code),
        .resolved(resolved), .last_bit(last_bit)
    );

    sar_pack #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_pack (
        .value(resolved), .right_just(fmt_q), .pair(packed_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q    <= 1'b0;
            res_q    <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (ctl_we) fmt_q <= ctl_fmt;
            if (load_fire) begin
                res_q <= packed_val;
            end else begin
                if (res_hi_we) res_q[PAIR_W-1:BYTE_W] <= res_wdata;
                if (res_lo_we) res_q[BYTE_W-1:0]      <= res_wdata;
            end
            if (load_fire)     irq_flag <= 1'b1;
            else if (flag_clr) irq_flag <= 1'b0;
        end
    end

    assign res_hi = res_q[PAIR_W-1:BYTE_W];
    assign res_lo = res_q[BYTE_W-1:0];

    assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> (irq_flag && !busy && sample_on));
    assert_left_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && !fmt_q) |=> (res_q[PAD_W-1:0] == '0));
    assert_right_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && fmt_q) |=> (res_q[PAIR_W-1 -: PAD_W] == '0));
    assert_abort_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_fire && !res_hi_we && !res_lo_we) |=> ($stable(res_q) && !$rose(irq_flag)));
    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);
endmodule

// File: tb/test_sar_seq.sv
module test_sar_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 0, ctl_en = 0, ctl_go = 0, ctl_fmt = 0, flag_clr = 0;
    logic res_hi_we = 0, res_lo_we = 0;
    logic [7:0] res_wdata = 8'h00;
    logic conv_tick = 0;
    logic cmp_below;
    logic busy, sample_on, irq_flag;
    logic [9:0] dac_code;
    logic [7:0] res_hi, res_lo;
    logic [9:0] vin = 10'd0;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign cmp_below = (vin < dac_code);

    sar_seq i_sar_seq (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_go(ctl_go),
        .ctl_fmt(ctl_fmt), .flag_clr(flag_clr), .res_hi_we(res_hi_we),
        .res_lo_we(res_lo_we), .res_wdata(res_wdata), .conv_tick(conv_tick),
        .cmp_below(cmp_below), .busy(busy), .sample_on(sample_on),
        .dac_code(dac_code), .res_hi(res_hi), .res_lo(res_lo), .irq_flag(irq_flag)
    );

    task automatic clk1;
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input bit en, input bit go, input bit fmt);
        ctl_we = 1; ctl_en = en; ctl_go = go; ctl_fmt = fmt;
        clk1;
        ctl_we = 0; ctl_go = 0;
    endtask

    task automatic tick1;
        clk1;
        conv_tick = 1;
        clk1;
        conv_tick = 0;
    endtask

    task automatic run_conv(input int v, input bit f, input int gap);
        int exp_hi, exp_lo;
        vin = 10'(v);
        ctl_write(1, 0, f);
        ctl_write(1, 1, f);
        check(busy && !sample_on && dac_code == 0, "R3", {busy, sample_on}, 2);
        repeat (gap) clk1;
        check(busy && dac_code == 0, "R3", dac_code, 0);
        conv_tick = 1; clk1; conv_tick = 0;
        check(dac_code == 10'h200, "R4", dac_code, 10'h200);
        for (int k = 9; k >= 0; k--) begin
            tick1;
            if (k > 0) begin
                int e;
                e = (v & ~((1 << k) - 1)) | (1 << (k - 1));
                check(busy && dac_code == e, "R5", dac_code, e);
            end else begin
                check(!busy && sample_on && irq_flag && dac_code == 0, "R6",
                      {busy, sample_on, irq_flag}, 3'b011);
            end
        end
        if (!f) begin
            exp_hi = v >> 2; exp_lo = (v & 3) << 6;
            check(res_hi == exp_hi && res_lo == exp_lo, "R7", {res_hi, res_lo}, {exp_hi[7:0], exp_lo[7:0]});
        end else begin
            exp_hi = v >> 8; exp_lo = v & 255;
            check(res_hi == exp_hi && res_lo == exp_lo, "R8", {res_hi, res_lo}, {exp_hi[7:0], exp_lo[7:0]});
        end
        clk1;
        check(irq_flag, "R10", irq_flag, 1);
        flag_clr = 1; clk1; flag_clr = 0;
        check(!irq_flag, "R10", irq_flag, 0);
    endtask

    initial begin
        repeat (3) clk1;
        check(!busy && sample_on && dac_code == 0 && !irq_flag && res_hi == 0 && res_lo == 0,
              "R1", {busy, sample_on, irq_flag}, 3'b010);
        rst_n = 1;
        clk1;
        check(!busy && sample_on && dac_code == 0, "R1", busy, 0);

        // R11: byte writes while disabled
        res_wdata = 8'hA5; res_hi_we = 1; clk1; res_hi_we = 0;
        res_wdata = 8'h3C; res_lo_we = 1; clk1; res_lo_we = 0;
        check(res_hi == 8'hA5 && res_lo == 8'h3C, "R11", {res_hi, res_lo}, 16'hA53C);

        // R2: start refused while disabled and in the enabling write
        ctl_write(0, 1, 0);
        check(!busy, "R2", busy, 0);
        ctl_write(1, 1, 0);
        check(!busy, "R2", busy, 0);
        tick1;
        check(!busy && dac_code == 0, "R2", dac_code, 0);

        // R9: abort mid-search
        vin = 10'd700;
        ctl_write(1, 1, 0);
        check(busy, "R2", busy, 1);
        tick1; tick1; tick1;
        ctl_write(1, 0, 0);
        check(!busy && sample_on && dac_code == 0 && !irq_flag, "R9",
              {busy, sample_on, irq_flag}, 3'b010);
        check(res_hi == 8'hA5 && res_lo == 8'h3C, "R9", {res_hi, res_lo}, 16'hA53C);
        for (int i = 0; i < 12; i++) tick1;
        check(!busy && !irq_flag && res_hi == 8'hA5 && res_lo == 8'h3C, "R9",
              {res_hi, res_lo}, 16'hA53C);

        // R12: disable mid-search
        ctl_write(1, 1, 1);
        tick1; tick1;
        ctl_write(0, 0, 1);
        check(!busy && sample_on && dac_code == 0, "R12", busy, 0);
        for (int i = 0; i < 12; i++) tick1;
        check(!irq_flag && res_hi == 8'hA5 && res_lo == 8'h3C, "R12",
              {res_hi, res_lo}, 16'hA53C);
        ctl_write(1, 1, 0);
        check(!busy, "R12", busy, 0);

        // extremes in both formats, then the full sweep
        run_conv(0, 0, 0);
        run_conv(1023, 0, 2);
        run_conv(0, 1, 1);
        run_conv(1023, 1, 0);
        for (int v = 0; v < 1024; v++) run_conv(v, v[0] ^ v[5], v % 3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule